// File: doc/BRIEF.md
# Processor status trace encoder

The encoder sits beside a processor core and turns per-cycle execution events into a compact byte stream. Each entry is tagged either as a status marker or as a data byte that belongs to the marker before it. Retired instructions are gathered into run-length markers, and a taken branch is reported with a marker. When capture is enabled, the branch target follows in two or three bytes. A breakpoint-state change is reported with the new state. Four long-lasting processor modes (exception, emulator exception, stopped, halted) are each reported for at most two cycles per stay.

Each marker and its data bytes form a group. A group enters a 16-entry trace FIFO whole or not at all. A dropped group sets a sticky overflow flag, which the consumer clears. The consumer drains the FIFO through a valid/read-enable port.

Top module: `pst_trace_enc`

## Requirements
- R1: Every cycle with `branch_i` high produces a marker 0x05.
- R2: Retire pulses gather into a run of length n. The run is emitted as 0x01 for n = 1, or as 0x12 + (n - 2) for 2 to 10. A run that reaches 10 is emitted in that same cycle.
- R3: A pending run is flushed in any cycle that emits another marker, and it counts a retire pulse arriving in that cycle.
- R4: With `br_capture_i` low, a branch gives 0x05 only. With it high and `br_wide_i` low, 0x05 is followed by marker 0x0D and two data bytes of target bits [16:1]. With `br_wide_i` high, 0x05 is followed by 0x0E and three data bytes of bits [23:1]. Data bytes go least significant first.
- R5: A cycle with `bp_chg_i` high produces marker 0x1B, then one data byte equal to 0x20 + 2 × `bp_state_i`.
- R6: Bits 0..3 of `mode_i` select codes 0x1C, 0x1D, 0x1E and 0x1F. While a bit stays high, its code appears in at most its first two cycles. A new report starts only after the bit has been low.
- R7: Groups produced in one cycle enter the FIFO in this order: run, branch, breakpoint, then modes in bit order.
- R8: A group that does not fit the free FIFO space is dropped whole, and later, smaller groups of that cycle may still enter. A drop sets `overflow_o`, which stays set until `clr_ovf_i`. A drop in the same cycle as a clear wins.
- R9: `rd_valid_o` shows a non-empty FIFO. `rd_is_data_o` is 1 for data bytes and 0 for markers. `rd_en_i` pops the head at the clock edge. After reset the FIFO is empty and the overflow flag is clear.
- R10: The marker values 0x0C, 0x0F, 0x10 and 0x11 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction completed sequentially |
| branch_i | input | 1 | Taken branch starts |
| br_target_i | input | ADDR_W-1 | Branch target, bits [ADDR_W-1:1] |
| br_capture_i | input | 1 | Append target bytes to branch markers |
| br_wide_i | input | 1 | 0: two target bytes, 1: three |
| bp_chg_i | input | 1 | Breakpoint state changed |
| bp_state_i | input | BP_W | New breakpoint state |
| mode_i | input | NMODE | Mode levels: exception, emulator exception, stopped, halted |
| rd_en_i | input | 1 | Pop FIFO head |
| rd_valid_o | output | 1 | FIFO head valid |
| rd_data_o | output | 8 | Head byte |
| rd_is_data_o | output | 1 | Head is a data byte |
| clr_ovf_i | input | 1 | Clear overflow flag |
| overflow_o | output | 1 | Sticky group-drop flag |

## Verification
The hardest case to reach is a partial fit. In it, a middle group of one cycle is dropped while a later, smaller group of the same cycle still enters the last free slot. The bench gets there by filling the FIFO with exactly seven breakpoint groups and no reads, then firing a capture-free branch, a breakpoint change and a mode entry in one cycle. It also fires a breakpoint change against a full FIFO in the same cycle as a clear, to show that the drop wins.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef struct packed {
    logic       is_data;
    logic [7:0] val;
  } ent_t;

  localparam int unsigned GRP_LEN_MAX = 5;
  localparam logic [7:0] C_BRANCH   = 8'h05;
  localparam logic [7:0] C_ADDR2    = 8'h0D;
  localparam logic [7:0] C_ADDR3    = 8'h0E;
  localparam logic [7:0] C_RUN1     = 8'h01;
  localparam logic [7:0] C_RUN_BASE = 8'h12;
  localparam logic [7:0] C_BP       = 8'h1B;
  localparam logic [7:0] C_BP_DATA  = 8'h20;
  localparam logic [7:0] C_MODE     = 8'h1C;
endpackage

// File: rtl/pst_run_ctr.sv
module pst_run_ctr #(
  parameter int unsigned RUN_MAX = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       retire_i,
  input  logic       other_i,
  output logic       emit_o,
  output logic [7:0] code_o
);
  localparam int unsigned CW = $clog2(RUN_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n  = cnt_q + CW'(retire_i);
    emit_o = (cnt_n == CW'(RUN_MAX)) || (other_i && cnt_n != '0);
    code_o = (cnt_n == CW'(1)) ? pst_pkg::C_RUN1
                               : pst_pkg::C_RUN_BASE + 8'(cnt_n) - 8'd2;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (emit_o) cnt_q <= '0;
    else             cnt_q <= cnt_n;
endmodule

// File: rtl/pst_mode_gate.sv
module pst_mode_gate #(
  parameter int unsigned REPORTS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  output logic emit_o
);
  localparam int unsigned CW = $clog2(REPORTS + 1);

  logic [CW-1:0] cnt_q;

  assign emit_o = mode_i && (cnt_q < CW'(REPORTS));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (!mode_i) cnt_q <= '0;
    else if (emit_o)  cnt_q <= cnt_q + CW'(1);
endmodule

// File: rtl/pst_group_fifo.sv
module pst_group_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SLOTS = 12,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned WCW = $clog2(SLOTS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  pst_pkg::ent_t [SLOTS-1:0]        wr_ent_i,
  input  logic [WCW-1:0]                   wr_cnt_i,
  input  logic                             rd_en_i,
  output pst_pkg::ent_t                    rd_ent_o,
  output logic                             valid_o,
  output logic [AW:0]                      free_o
);
  pst_pkg::ent_t mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          pop;

  assign valid_o  = cnt_q != '0;
  assign pop      = rd_en_i && valid_o;
  assign rd_ent_o = mem[rptr_q];
  assign free_o   = (AW+1)'(DEPTH) - cnt_q;

  always_ff @(posedge clk_i)
    for (int i = 0; i < int'(SLOTS); i++)
      if (i < int'(wr_cnt_i)) mem[wptr_q + AW'(i)] <= wr_ent_i[i];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(wr_cnt_i);
      rptr_q <= rptr_q + AW'(pop);
      cnt_q  <= cnt_q + (AW+1)'(wr_cnt_i) - (AW+1)'(pop);
    end
endmodule

// File: rtl/pst_trace_enc.sv
module pst_trace_enc #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RUN_MAX = 10,
  parameter int unsigned BP_W    = 3,
  parameter int unsigned NMODE   = 4,
  parameter int unsigned REPORTS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:1] br_target_i,
  input  logic              br_capture_i,
  input  logic              br_wide_i,
  input  logic              bp_chg_i,
  input  logic [BP_W-1:0]   bp_state_i,
  input  logic [NMODE-1:0]  mode_i,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_is_data_o,
  input  logic              clr_ovf_i,
  output logic              overflow_o
);
  import pst_pkg::*;

  localparam int unsigned NGRP  = 3 + NMODE;
  localparam int unsigned GLEN  = GRP_LEN_MAX;
  localparam int unsigned SLOTS = 1 + GLEN + 2 + NMODE;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned WCW   = $clog2(SLOTS + 1);

  logic               run_emit;
  logic [7:0]         run_code;
  logic [NMODE-1:0]   mode_emit;
  logic               other;
  ent_t               grp_ent [NGRP][GLEN];
  logic [2:0]         grp_len [NGRP];
  ent_t [SLOTS-1:0]   wr_ent;
  logic [WCW-1:0]     wr_cnt;
  logic               drop_any;
  logic [AW:0]        free;
  ent_t               rd_ent;
  logic               ovf_q;

  assign other = branch_i || bp_chg_i || (|mode_emit);

  pst_run_ctr #(.RUN_MAX(RUN_MAX)) u_run (
    .clk_i, .rst_ni, .retire_i, .other_i(other),
    .emit_o(run_emit), .code_o(run_code)
  );

  for (genvar k = 0; k < NMODE; k++) begin : g_mode
    pst_mode_gate #(.REPORTS(REPORTS)) u_gate (
      .clk_i, .rst_ni, .mode_i(mode_i[k]), .emit_o(mode_emit[k])
    );
  end

  // group builder: fixed slot per event kind, in enqueue order
  always_comb begin
    for (int g = 0; g < int'(NGRP); g++) begin
      grp_len[g] = '0;
      for (int j = 0; j < int'(GLEN); j++) grp_ent[g][j] = '0;
    end
    if (run_emit) begin
      grp_len[0]    = 3'd1;
      grp_ent[0][0] = '{1'b0, run_code};
    end
    if (branch_i) begin
      grp_ent[1][0] = '{1'b0, C_BRANCH};
      grp_len[1]    = 3'd1;
      if (br_capture_i) begin
        grp_ent[1][1] = '{1'b0, br_wide_i ? C_ADDR3 : C_ADDR2};
        grp_ent[1][2] = '{1'b1, br_target_i[8:1]};
        grp_ent[1][3] = '{1'b1, br_target_i[16:9]};
        grp_ent[1][4] = '{1'b1, 8'(br_target_i[ADDR_W-1:17])};
        grp_len[1]    = br_wide_i ? 3'd5 : 3'd4;
      end
    end
    if (bp_chg_i) begin
      grp_len[2]    = 3'd2;
      grp_ent[2][0] = '{1'b0, C_BP};
      grp_ent[2][1] = '{1'b1, C_BP_DATA + 8'({bp_state_i, 1'b0})};
    end
    for (int k = 0; k < int'(NMODE); k++)
      if (mode_emit[k]) begin
        grp_len[3+k]    = 3'd1;
        grp_ent[3+k][0] = '{1'b0, C_MODE + 8'(k)};
      end
  end

  // atomic packing against free space
  always_comb begin
    int used;
    used     = 0;
    drop_any = 1'b0;
    wr_ent   = '0;
    for (int g = 0; g < int'(NGRP); g++) begin
      if (grp_len[g] != '0) begin
        if (used + int'(grp_len[g]) <= int'(free)) begin
          for (int j = 0; j < int'(GLEN); j++)
            if (j < int'(grp_len[g]) && (used + j) < int'(SLOTS))
              wr_ent[used+j] = grp_ent[g][j];
          used = used + int'(grp_len[g]);
        end else begin
          drop_any = 1'b1;
        end
      end
    end
    wr_cnt = WCW'(used);
  end

  pst_group_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_fifo (
    .clk_i, .rst_ni, .wr_ent_i(wr_ent), .wr_cnt_i(wr_cnt),
    .rd_en_i, .rd_ent_o(rd_ent), .valid_o(rd_valid_o), .free_o(free)
  );

  assign rd_data_o    = rd_ent.val;
  assign rd_is_data_o = rd_ent.is_data;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop_any)  ovf_q <= 1'b1;
    else if (clr_ovf_i) ovf_q <= 1'b0;

  assign overflow_o = ovf_q;
endmodule

// File: rtl/pst_trace_enc_chk.sv
module pst_trace_enc_chk #(
  parameter int unsigned NMODE = 4,
  parameter int unsigned SLOTS = 12,
  localparam int unsigned WCW  = $clog2(SLOTS + 1)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NMODE-1:0]          mode_i,
  input logic                      rd_en_i,
  input logic                      rd_valid_o,
  input logic [7:0]                rd_data_o,
  input logic                      rd_is_data_o,
  input logic                      clr_ovf_i,
  input logic                      overflow_o,
  input logic                      drop_any,
  input pst_pkg::ent_t [SLOTS-1:0] wr_ent,
  input logic [WCW-1:0]            wr_cnt
);
  logic [1:0]       age_q;
  logic [NMODE-1:0] seen;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;

  always_comb
    for (int k = 0; k < int'(NMODE); k++) begin
      seen[k] = 1'b0;
      for (int i = 0; i < int'(SLOTS); i++)
        if (i < int'(wr_cnt) && !wr_ent[i].is_data && wr_ent[i].val == 8'h1C + 8'(k))
          seen[k] = 1'b1;
    end

  AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_is_data_o |-> !(rd_data_o inside {8'h0C, 8'h0F, 8'h10, 8'h11})); // R10

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !clr_ovf_i |=> overflow_o); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ovf_i && !drop_any |=> !overflow_o); // R8

  AST_DROP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_any |=> overflow_o); // R8

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_en_i |=> rd_valid_o); // R9

  for (genvar k = 0; k < NMODE; k++) begin : g_mode_chk
    AST_MODE_TWICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      age_q == 2'd3 && mode_i[k] && $past(mode_i[k]) && $past(mode_i[k], 2) |-> !seen[k]); // R6
  end
endmodule

bind pst_trace_enc pst_trace_enc_chk #(.NMODE(NMODE), .SLOTS(SLOTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .rd_en_i(rd_en_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_is_data_o(rd_is_data_o),
  .clr_ovf_i(clr_ovf_i), .overflow_o(overflow_o), .drop_any(drop_any),
  .wr_ent(wr_ent), .wr_cnt(wr_cnt)
);

// File: tb/pst_trace_enc_tb.sv
`timescale 1ns/1ps
module pst_trace_enc_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire = 0, branch = 0, cap = 0, wide = 0, bp_chg = 0, rd_en = 0, clr = 0;
  logic [23:1] target = '0;
  logic [2:0]  bp_state = '0;
  logic [3:0]  mode = '0;
  logic        rd_valid, rd_is_data, overflow;
  logic [7:0]  rd_data;

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_mem [0:63];
  int n_exp = 0;

  always #2.5 clk = ~clk;

  pst_trace_enc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .retire_i(retire), .branch_i(branch),
    .br_target_i(target), .br_capture_i(cap), .br_wide_i(wide),
    .bp_chg_i(bp_chg), .bp_state_i(bp_state), .mode_i(mode),
    .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rd_is_data_o(rd_is_data), .clr_ovf_i(clr), .overflow_o(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic push(input bit d, input logic [7:0] v);
    exp_mem[n_exp] = {d, v};
    n_exp++;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    retire = 0; branch = 0; bp_chg = 0; mode = '0; clr = 0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < n_exp; i++) begin
      @(negedge clk);
      chk(rd_valid && {rd_is_data, rd_data} == exp_mem[i], req,
          {22'd0, rd_valid, rd_is_data, rd_data}, {23'd1, exp_mem[i]});
      if (!rd_is_data)
        chk(!(rd_data inside {8'h0C, 8'h0F, 8'h10, 8'h11}), "R10", {24'd0, rd_data}, 32'd0);
      rd_en = 1;
    end
    @(negedge clk);
    rd_en = 0;
    chk(!rd_valid, {req, " R9 empty"}, {31'd0, rd_valid}, 32'd0);
    n_exp = 0;
  endtask

  function automatic logic [7:0] run_code(input int n);
    return (n == 1) ? 8'h01 : 8'(8'h12 + n - 2);
  endfunction

  task automatic push_branch(input logic [23:1] a, input bit c, input bit w);
    push(0, 8'h05);
    if (c) begin
      push(0, w ? 8'h0E : 8'h0D);
      push(1, a[8:1]);
      push(1, a[16:9]);
      if (w) push(1, {1'b0, a[23:17]});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL R9 watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(!rd_valid && !overflow, "R9 reset", {30'd0, rd_valid, overflow}, 32'd0);
    rst_ni = 1;
    tick();
    chk(!rd_valid && !overflow, "R9 after reset", {30'd0, rd_valid, overflow}, 32'd0);

    // R2 R1: run lengths 1..25 closed by a plain branch
    for (int n = 1; n <= 25; n++) begin
      for (int i = 0; i < n; i++) begin retire = 1; tick(); end
      retire = 0; tick();
      branch = 1; cap = 0; tick(); idle();
      for (int k = 0; k < n / 10; k++) push(0, 8'h1A);
      if (n % 10 != 0) push(0, run_code(n % 10));
      push(0, 8'h05);
      drain("R2 run");
    end

    // R4: target capture both sizes
    for (int i = 0; i < 6; i++) begin
      for (int w = 0; w < 2; w++) begin
        logic [23:1] a;
        a = 23'(32'h52_9E3F ^ (i * 32'h12_3457));
        target = a; cap = 1; wide = w[0]; branch = 1; tick(); idle();
        push_branch(a, 1, w[0]);
        drain("R4 capture");
      end
    end

    // R5: every breakpoint state
    for (int s = 0; s < 8; s++) begin
      bp_state = 3'(s); bp_chg = 1; tick(); idle();
      push(0, 8'h1B); push(1, 8'(8'h20 + 2 * s));
      drain("R5 bp");
    end

    // R6: two reports per stay, re-arm after leaving
    for (int k = 0; k < 4; k++) begin
      mode[k] = 1; repeat (5) tick();
      mode = '0; repeat (2) tick();
      mode[k] = 1; tick(); mode = '0; tick();
      mode[k] = 1; repeat (3) tick(); mode = '0; tick();
      for (int r = 0; r < 5; r++) push(0, 8'(8'h1C + k));
      drain("R6 mode");
    end

    // R3: retire coinciding with branch is part of the flushed run
    retire = 1; tick(); tick();
    branch = 1; cap = 0; tick(); idle();
    push(0, 8'h13); push(0, 8'h05);
    drain("R3 flush");

    // R7: all kinds in one cycle
    target = 23'h5A_C3E1; cap = 1; wide = 1;
    retire = 1; branch = 1; bp_chg = 1; bp_state = 3'd2; mode = 4'b1000; tick();
    retire = 0; branch = 0; bp_chg = 0; tick(); tick();
    idle(); tick();
    push(0, 8'h01); push_branch(23'h5A_C3E1, 1, 1);
    push(0, 8'h1B); push(1, 8'h24); push(0, 8'h1F); push(0, 8'h1F);
    drain("R7 order");

    // R8: full FIFO drops whole groups
    for (int s = 0; s < 8; s++) begin
      bp_state = 3'(s); bp_chg = 1; tick(); idle();
      push(0, 8'h1B); push(1, 8'(8'h20 + 2 * s));
    end
    chk(!overflow, "R8 exact fill", {31'd0, overflow}, 32'd0);
    bp_state = 3'd1; bp_chg = 1; tick(); idle();
    chk(overflow, "R8 drop sets", {31'd0, overflow}, 32'd1);
    branch = 1; cap = 1; wide = 0; tick(); idle(); tick();
    drain("R8 full");
    chk(overflow, "R8 sticky", {31'd0, overflow}, 32'd1);
    clr = 1; tick(); idle();
    chk(!overflow, "R8 clear", {31'd0, overflow}, 32'd0);

    // R8 partial fit: middle group dropped, later one accepted
    for (int s = 0; s < 7; s++) begin
      bp_state = 3'(s); bp_chg = 1; tick(); idle();
      push(0, 8'h1B); push(1, 8'(8'h20 + 2 * s));
    end
    branch = 1; cap = 0; bp_chg = 1; bp_state = 3'd3; mode = 4'b0001; tick(); idle();
    push(0, 8'h05); push(0, 8'h1C);
    chk(overflow, "R8 partial drop", {31'd0, overflow}, 32'd1);
    clr = 1; bp_chg = 1; tick(); idle();
    chk(overflow, "R8 drop beats clear", {31'd0, overflow}, 32'd1);
    clr = 1; tick(); idle();
    chk(!overflow, "R8 clear again", {31'd0, overflow}, 32'd0);
    drain("R8 partial");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule